// File: doc/BRIEF.md
# Boot Overlay Address Decoder

This block decodes the 24-bit address of a 68000-class system bus. For each access it raises one chip select (RAM, ROM, serial controller, disk controller, peripheral port chip, an ignored phase window or an ignored debugger probe window) or flags the access as a bus error. For memory accesses it also supplies the address folded into the memory's own size. For device accesses it supplies a 4-bit register index.

The lower 8 MB of the map has two layouts. A one-bit overlay state selects between them. The overlay is taken from bit 4 of every write to the peripheral chip's port A output, and it resets to 1. In the startup layout, ROM answers at address zero so that the reset vectors can be fetched. Once software clears the bit, RAM moves down to address zero and ROM moves up to the middle of the lower map. Each memory is mirrored across its window: the offset is the address modulo the memory size.

The decode is combinational. Chip selects, the folded offset, the register index and the error flag all follow the address in the same cycle. Only the overlay state is registered.

Top module: `boot_map_decoder`

## Requirements
- R1: After reset the overlay output is 1 (startup layout).
- R2: On a cycle with `ovl_wr` high, `overlay` takes `ovl_data[4]` from the next clock edge on. The other bits of `ovl_data` have no effect. Without `ovl_wr`, the overlay holds its value.
- R3: With overlay 0, addresses 0x000000–0x3FFFFF select RAM, and `mem_off` is the address modulo 512 KB.
- R4: With overlay 0, addresses 0x400000–0x7FFFFF select ROM, and `mem_off` is the address modulo 128 KB.
- R5: With overlay 1, addresses 0x000000–0x5FFFFF select ROM (offset modulo 128 KB), and 0x600000–0x7FFFFF select RAM (offset modulo 512 KB).
- R6: Addresses 0x900000–0x9FFFFF and 0xB00000–0xBFFFFF select the serial controller.
- R7: Addresses 0xD00000–0xDFFFFF select the disk controller. Addresses 0xE80000–0xEFFFFF select the peripheral port chip.
- R8: When the serial, disk or peripheral select is active, `dev_reg` equals address bits [12:9]. Otherwise `dev_reg` is 0, and `mem_off` is 0 whenever no memory is selected.
- R9: Reads and writes to 0xF00000–0xF7FFFF raise `sel_phase` only, with no error.
- R10: Reads of 0xF80000–0xF8000F raise `sel_probe` only. Writes to that window raise `bus_err`.
- R11: Every other valid access raises `bus_err` in the same cycle and no select.
- R12: At most one of the seven selects and `bus_err` is high. With `acc_valid` low, all of them are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Bus access present this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 24 | Byte address of the access |
| ovl_wr | input | 1 | Write strobe of the peripheral chip's port A output |
| ovl_data | input | 8 | Value written to port A; bit 4 is the overlay |
| sel_ram | output | 1 | RAM select |
| sel_rom | output | 1 | ROM select |
| sel_serial | output | 1 | Serial controller select |
| sel_disk | output | 1 | Disk controller select |
| sel_via | output | 1 | Peripheral port chip select |
| sel_phase | output | 1 | Phase window accepted and ignored |
| sel_probe | output | 1 | Debugger probe read accepted and ignored |
| bus_err | output | 1 | Access to unmapped space |
| mem_off | output | 19 | Folded offset into RAM or ROM |
| dev_reg | output | 4 | Device register index |
| overlay | output | 1 | Current overlay state (1 = startup layout) |

## Verification
The only stored state is the overlay bit. If it is wrong, every lower-map access after the faulty port write reports the wrong memory, starting at the first access one clock after the write. The bench therefore mixes port writes into random traffic, so that both layouts are exercised. A wrong window edge or a wrong fold mask shows at once, in the same cycle as the access. It appears as a wrong select, a missing or spurious `bus_err`, or a wrong `mem_off`. For that reason the directed cases sit on the first and last byte of every window.

// File: rtl/boot_map_pkg.sv
package boot_map_pkg;

  // Upper-map decode constants (24-bit bus)
  localparam logic [3:0]  NIB_SERIAL_A = 4'h9;
  localparam logic [3:0]  NIB_SERIAL_B = 4'hB;
  localparam logic [3:0]  NIB_DISK     = 4'hD;
  localparam logic [4:0]  HALF_VIA     = 5'h1D;  // 0xE80000 >> 19
  localparam logic [4:0]  HALF_PHASE   = 5'h1E;  // 0xF00000 >> 19
  localparam logic [19:0] PROBE_TAG    = 20'hF8000;

  // Keep the low aw bits of an address: offset modulo a power-of-two size
  function automatic logic [31:0] fold_addr(input logic [31:0] a, input int unsigned aw);
    return a & ((32'd1 << aw) - 32'd1);
  endfunction

  // Register index field of a device access
  function automatic logic [31:0] reg_field(input logic [31:0] a, input int unsigned lsb,
                                            input int unsigned w);
    return (a >> lsb) & ((32'd1 << w) - 32'd1);
  endfunction

endpackage

// File: rtl/boot_overlay_reg.sv
module boot_overlay_reg #(
  parameter int PORT_W  = 8,
  parameter int OVL_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [PORT_W-1:0] data,
  output logic              overlay
);

  // Port output resets to all ones, so the overlay starts in startup layout
  always_ff @(posedge clk) begin
    if (!rst_n)
      overlay <= 1'b1;
    else if (wr)
      overlay <= data[OVL_BIT];
  end

endmodule

// File: rtl/boot_lower_map.sv
module boot_lower_map
  import boot_map_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int RAM_AW = 19,
  parameter int ROM_AW = 17,
  parameter int MEM_AW = 19
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              overlay,
  output logic              hit,
  output logic              is_ram,
  output logic              is_rom,
  output logic [MEM_AW-1:0] off
);

  logic [1:0] quarter;  // which 2 MB slice of the lower 8 MB
  assign quarter = addr[ADDR_W-2 -: 2];

  always_comb begin
    hit = ~addr[ADDR_W-1];
    if (overlay)
      is_ram = hit & (quarter == 2'b11);
    else
      is_ram = hit & ~quarter[1];
    is_rom = hit & ~is_ram;
    if (is_ram)
      off = MEM_AW'(fold_addr(32'(addr), RAM_AW));
    else if (is_rom)
      off = MEM_AW'(fold_addr(32'(addr), ROM_AW));
    else
      off = '0;
  end

endmodule

// File: rtl/boot_io_map.sv
module boot_io_map
  import boot_map_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int REG_LSB = 9,
  parameter int REG_W   = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              is_serial,
  output logic              is_disk,
  output logic              is_via,
  output logic              is_phase,
  output logic              is_probe,
  output logic [REG_W-1:0]  reg_idx
);

  logic [3:0] nib;
  logic [4:0] half;
  assign nib  = addr[ADDR_W-1 -: 4];
  assign half = addr[ADDR_W-1 -: 5];

  always_comb begin
    is_serial = (nib == NIB_SERIAL_A) | (nib == NIB_SERIAL_B);
    is_disk   = (nib == NIB_DISK);
    is_via    = (half == HALF_VIA);
    is_phase  = (half == HALF_PHASE);
    is_probe  = (addr[ADDR_W-1:4] == PROBE_TAG);
    reg_idx   = REG_W'(reg_field(32'(addr), REG_LSB, REG_W));
  end

endmodule

// File: rtl/boot_map_decoder.sv
module boot_map_decoder #(
  parameter int ADDR_W  = 24,
  parameter int RAM_AW  = 19,
  parameter int ROM_AW  = 17,
  parameter int PORT_W  = 8,
  parameter int OVL_BIT = 4,
  parameter int REG_LSB = 9,
  parameter int REG_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              ovl_wr,
  input  logic [PORT_W-1:0] ovl_data,
  output logic              sel_ram,
  output logic              sel_rom,
  output logic              sel_serial,
  output logic              sel_disk,
  output logic              sel_via,
  output logic              sel_phase,
  output logic              sel_probe,
  output logic              bus_err,
  output logic [18:0]       mem_off,
  output logic [REG_W-1:0]  dev_reg,
  output logic              overlay
);

  localparam int MEM_AW = (RAM_AW > ROM_AW) ? RAM_AW : ROM_AW;

  logic              lm_hit, lm_ram, lm_rom;
  logic [MEM_AW-1:0] lm_off;
  logic              io_serial, io_disk, io_via, io_phase, io_probe;
  logic [REG_W-1:0]  io_reg;

  // Named internal events
  logic hit_dev;       // one of the three register-mapped devices
  logic probe_wr_err;  // write into the read-only probe window
  logic accepted;      // address is served by something

  boot_overlay_reg #(.PORT_W(PORT_W), .OVL_BIT(OVL_BIT)) i_ovl (
    .clk(clk), .rst_n(rst_n), .wr(ovl_wr), .data(ovl_data), .overlay(overlay)
  );

  boot_lower_map #(.ADDR_W(ADDR_W), .RAM_AW(RAM_AW), .ROM_AW(ROM_AW), .MEM_AW(MEM_AW)) i_lower (
    .addr(acc_addr), .overlay(overlay), .hit(lm_hit), .is_ram(lm_ram),
    .is_rom(lm_rom), .off(lm_off)
  );

  boot_io_map #(.ADDR_W(ADDR_W), .REG_LSB(REG_LSB), .REG_W(REG_W)) i_io (
    .addr(acc_addr), .is_serial(io_serial), .is_disk(io_disk), .is_via(io_via),
    .is_phase(io_phase), .is_probe(io_probe), .reg_idx(io_reg)
  );

  always_comb begin
    hit_dev      = io_serial | io_disk | io_via;
    probe_wr_err = io_probe & acc_we;
    accepted     = lm_hit | hit_dev | io_phase | (io_probe & ~acc_we);

    sel_ram    = acc_valid & lm_ram;
    sel_rom    = acc_valid & lm_rom;
    sel_serial = acc_valid & io_serial;
    sel_disk   = acc_valid & io_disk;
    sel_via    = acc_valid & io_via;
    sel_phase  = acc_valid & io_phase;
    sel_probe  = acc_valid & io_probe & ~acc_we;
    bus_err    = acc_valid & ~accepted;

    mem_off = acc_valid ? 19'(lm_off) : '0;
    dev_reg = (acc_valid & hit_dev) ? io_reg : '0;
  end

endmodule

// File: rtl/boot_map_checker.sv
module boot_map_checker #(
  parameter int ADDR_W  = 24,
  parameter int PORT_W  = 8,
  parameter int OVL_BIT = 4,
  parameter int REG_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              acc_we,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              ovl_wr,
  input logic [PORT_W-1:0] ovl_data,
  input logic              sel_ram,
  input logic              sel_rom,
  input logic              sel_serial,
  input logic              sel_disk,
  input logic              sel_via,
  input logic              sel_phase,
  input logic              sel_probe,
  input logic              bus_err,
  input logic [18:0]       mem_off,
  input logic [REG_W-1:0]  dev_reg,
  input logic              overlay
);

  logic [7:0] outs;
  assign outs = {sel_ram, sel_rom, sel_serial, sel_disk, sel_via, sel_phase, sel_probe, bus_err};

  // R12
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(outs));

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !acc_valid |-> (outs == 8'h00));

  // R2
  ovl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_wr |=> (overlay == $past(ovl_data[OVL_BIT])));

  // R2
  ovl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !ovl_wr |=> $stable(overlay));

  // R3
  normal_ram_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ram && !overlay) |-> (acc_addr[ADDR_W-1 -: 2] == 2'b00));

  // R7
  via_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_via |-> (acc_addr[ADDR_W-1 -: 5] == 5'h1D));

  // R10
  probe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_we && acc_addr[ADDR_W-1:4] == 20'hF8000) |-> bus_err);

endmodule

bind boot_map_decoder boot_map_checker #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .OVL_BIT(OVL_BIT), .REG_W(REG_W)) i_chk (.*);

// File: tb/test_boot_map_decoder.sv
module test_boot_map_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_we = 1'b0, ovl_wr = 1'b0;
  logic [23:0] acc_addr = '0;
  logic [7:0]  ovl_data = '0;
  logic        sel_ram, sel_rom, sel_serial, sel_disk, sel_via, sel_phase, sel_probe, bus_err;
  logic [18:0] mem_off;
  logic [3:0]  dev_reg;
  logic        overlay;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic exp_ovl = 1'b1;

  always #2.5 clk = ~clk;

  boot_map_decoder i_boot_map_decoder (.*);

  task automatic check(input string tag, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // Expected outputs from the address map, worked out with plain arithmetic
  task automatic model(input bit v, input bit we, input int unsigned a, input bit ov,
                       output logic [7:0] sel, output int unsigned off,
                       output int unsigned rg, output string tag);
    sel = 8'h00; off = 0; rg = 0; tag = "R12";
    if (!v) return;
    if (a < 24'h800000) begin
      bit ram;
      if (ov) ram = (a >= 24'h600000); else ram = (a < 24'h400000);
      if (ram) begin sel = 8'h80; off = a % 524288; end
      else     begin sel = 8'h40; off = a % 131072; end
      tag = ov ? "R5" : (ram ? "R3" : "R4");
    end else if ((a >= 24'h900000 && a < 24'hA00000) || (a >= 24'hB00000 && a < 24'hC00000)) begin
      sel = 8'h20; rg = (a / 512) % 16; tag = "R6";
    end else if (a >= 24'hD00000 && a < 24'hE00000) begin
      sel = 8'h10; rg = (a / 512) % 16; tag = "R7";
    end else if (a >= 24'hE80000 && a < 24'hF00000) begin
      sel = 8'h08; rg = (a / 512) % 16; tag = "R7";
    end else if (a >= 24'hF00000 && a < 24'hF80000) begin
      sel = 8'h04; tag = "R9";
    end else if (a >= 24'hF80000 && a < 24'hF80010) begin
      sel = we ? 8'h01 : 8'h02; tag = "R10";
    end else begin
      sel = 8'h01; tag = "R11";
    end
  endtask

  task automatic access(input bit v, input bit we, input logic [23:0] a,
                        input bit pw, input logic [7:0] pd);
    logic [7:0] es; int unsigned eo, er; string tag;
    @(negedge clk);
    acc_valid = v; acc_we = we; acc_addr = a; ovl_wr = pw; ovl_data = pd;
    #1;
    model(v, we, 32'(a), exp_ovl, es, eo, er, tag);
    check("R2", "overlay", int'(overlay), int'(exp_ovl));
    check(tag, "selects", int'({sel_ram, sel_rom, sel_serial, sel_disk, sel_via,
                                sel_phase, sel_probe, bus_err}), int'(es));
    check(tag, "mem_off", int'(mem_off), int'(eo));
    check("R8", "dev_reg", int'(dev_reg), int'(er));
    @(posedge clk);
    if (pw) exp_ovl = pd[4];
  endtask

  initial begin
    void'($urandom(32'h0B00_7ED5));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1: startup layout after reset
    check("R1", "overlay after reset", int'(overlay), 1);

    // R5 startup layout corners
    access(1, 0, 24'h000000, 0, 8'h00);
    access(1, 0, 24'h3FFFFE, 0, 8'h00);
    access(1, 1, 24'h5FFFFF, 0, 8'h00);
    access(1, 0, 24'h600000, 0, 8'h00);
    access(1, 1, 24'h7FFFFF, 0, 8'h00);
    // R2: other bits set, bit 4 clear -> normal layout
    access(0, 0, 24'h000000, 1, 8'hEF);
    access(1, 0, 24'h000000, 0, 8'h00);
    access(1, 0, 24'h3FFFFF, 0, 8'h00);
    access(1, 0, 24'h400000, 0, 8'h00);
    access(1, 0, 24'h7FFFFF, 0, 8'h00);
    // upper map edges
    access(1, 0, 24'h800000, 0, 8'h00);
    access(1, 0, 24'h8FFFFF, 0, 8'h00);
    access(1, 0, 24'h900000, 0, 8'h00);
    access(1, 1, 24'h9FFE00, 0, 8'h00);
    access(1, 0, 24'hA00000, 0, 8'h00);
    access(1, 0, 24'hBFFFFF, 0, 8'h00);
    access(1, 0, 24'hC00000, 0, 8'h00);
    access(1, 0, 24'hDFE1FF, 0, 8'h00);
    access(1, 0, 24'hE7FFFF, 0, 8'h00);
    access(1, 0, 24'hE80000, 0, 8'h00);
    access(1, 1, 24'hEFFFFF, 0, 8'h00);
    access(1, 0, 24'hF00000, 0, 8'h00);
    access(1, 1, 24'hF7FFFF, 0, 8'h00);
    access(1, 0, 24'hF80000, 0, 8'h00);
    access(1, 0, 24'hF8000F, 0, 8'h00);
    access(1, 1, 24'hF80000, 0, 8'h00);
    access(1, 0, 24'hF80010, 0, 8'h00);
    access(1, 0, 24'hFFFFFF, 0, 8'h00);
    access(0, 1, 24'hF80000, 0, 8'h00);
    // R2: only bit 4 set -> back to startup
    access(0, 0, 24'h000000, 1, 8'h10);
    access(1, 0, 24'h000000, 0, 8'h00);

    // Random traffic with occasional overlay writes
    for (int i = 0; i < 3000; i++) begin
      logic [23:0] a;
      a = 24'($urandom);
      if ($urandom_range(9) == 0) a = {20'hF8000, a[3:0]};
      access($urandom_range(7) != 0, 1'($urandom), a,
             $urandom_range(15) == 0, 8'($urandom));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule